// File: doc/BRIEF.md
# Strided Padded Direct Convolution Engine

This block computes one convolution layer by direct evaluation. After a start pulse it walks every pixel of every output channel. For each pixel it sweeps all input channels and all kernel rows and columns, reads one input feature word and one weight word per cycle, and accumulates their signed products. When the sweep for a pixel is complete, it writes the saturated sum to the output memory. The three memories are local on-chip arrays outside the block. The engine drives their addresses and receives read data in the same cycle. Output words are written through a simple write port.

The layer shape is set at run time:
- input channel count
- output channel count
- square input size
- square kernel size
- stride
- zero padding

The engine captures all six values when it accepts a start. Padding is never stored. A tap whose input position falls outside the real feature map is detected by a signed range test and contributes nothing. The index width is eight bits by default, so a 5×5 kernel over 48 input channels fits comfortably.

Top module: `conv_engine`

## Requirements
- R1: A start pulse is accepted only while `busy` is low. Accepting it captures the six configuration inputs, and `busy` rises on the next cycle. A start pulse, or a change of configuration inputs, while `busy` is high has no effect on the run in progress or on its results.
- R2: Output words are written at a running index that starts at 0 for each run and rises by one per pixel. The loop order is output channel (outermost), then output row, then output column, so each output channel occupies a contiguous address range.
- R3: For each tap, the input row is out_row·stride + kernel_row − padding and the input column is out_col·stride + kernel_col − padding. The tap contributes only when both lie in [0, input size); otherwise it contributes zero.
- R4: The input feature word for channel c, row r and column x is read at address (c·size + r)·size + x.
- R5: The weight for output channel o, input channel c, kernel row i and kernel column j is read at address ((o·in_channels + c)·kernel + i)·kernel + j.
- R6: Each output word is the sum, over all input channels and kernel taps, of 16-bit signed feature × 16-bit signed weight products. The sum is held at 48 bits and starts from zero for every pixel.
- R7: The 48-bit sum is clamped to the signed 32-bit range when written: above 2147483647 gives 2147483647, and below −2147483648 gives −2147483648.
- R8: The output size per side is (size + 2·padding − kernel) / stride + 1 (integer division). Exactly out_channels·out_size² words are written, and nothing beyond that address range.
- R9: `done` is high for exactly one cycle, the cycle after the last output write. It rises N+1 clock edges after the edge that accepted start, where N = out_channels·out_size²·in_channels·kernel². `busy` is low when `done` is high.
- R10: After reset, `busy`, `done` and `out_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| cfg_in_ch | input | IDX_W | Input channel count |
| cfg_out_ch | input | IDX_W | Output channel count |
| cfg_in_size | input | IDX_W | Input feature map side length |
| cfg_kernel | input | IDX_W | Kernel side length |
| cfg_stride | input | IDX_W | Stride, at least 1 |
| cfg_pad | input | IDX_W | Zero padding on each border |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fmap_addr | output | 3·IDX_W | Input feature memory read address |
| fmap_rdata | input | DATA_W | Input feature word, same cycle |
| wgt_addr | output | 4·IDX_W | Weight memory read address |
| wgt_rdata | input | DATA_W | Weight word, same cycle |
| out_we | output | 1 | Output memory write enable |
| out_addr | output | 3·IDX_W | Output memory write address |
| out_data | output | 2·DATA_W | Saturated output word |

## Verification
Two events can fall in the same cycle: an output write and a start request that must be ignored. The bench provokes this with a 1×1 kernel over one input channel, where every cycle of the run writes a word. It pulses start with a different configuration five cycles in, exactly on a write. The request is judged harmless only if three things hold: every output word still matches the model built from the original shape, the run length still equals N+1 edges, and the address just past the last output keeps its sentinel value.

// File: rtl/conv_pkg.sv
package conv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } eng_state_e;

    // Loop levels, innermost first
    localparam int unsigned NUM_LOOPS = 6;
    localparam int unsigned LP_KX = 0;
    localparam int unsigned LP_KY = 1;
    localparam int unsigned LP_IC = 2;
    localparam int unsigned LP_OX = 3;
    localparam int unsigned LP_OY = 4;
    localparam int unsigned LP_OC = 5;

endpackage

// File: rtl/conv_loop_nest.sv
module conv_loop_nest #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned LEVELS = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear,
    input  logic                             advance,
    input  logic [LEVELS-1:0][IDX_W-1:0]     limit,
    output logic [LEVELS-1:0][IDX_W-1:0]     count,
    output logic [LEVELS-1:0]                at_end
);

    typedef struct packed {
        logic [LEVELS-1:0][IDX_W-1:0] cnt;
    } nest_t;

    nest_t nest_q, nest_d;

    // Each level flags its last value
    for (genvar g = 0; g < LEVELS; g++) begin : g_end
        assign at_end[g] = (nest_q.cnt[g] == limit[g] - 1'b1);
    end

    // Ripple the carry outward from the innermost level
    always_comb begin
        logic carry;
        nest_d = nest_q;
        carry  = advance;
        for (int i = 0; i < LEVELS; i++) begin
            if (clear) begin
                nest_d.cnt[i] = '0;
            end else if (carry) begin
                if (at_end[i]) begin
                    nest_d.cnt[i] = '0;
                end else begin
                    nest_d.cnt[i] = nest_q.cnt[i] + 1'b1;
                    carry         = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nest_q <= '0;
        end else begin
            nest_q <= nest_d;
        end
    end

    assign count = nest_q.cnt;

endmodule

// File: rtl/conv_addr_gen.sv
module conv_addr_gen #(
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned FMAP_AW = 24,
    parameter int unsigned WGT_AW  = 32
) (
    input  logic [IDX_W-1:0]   oc,
    input  logic [IDX_W-1:0]   oy,
    input  logic [IDX_W-1:0]   ox,
    input  logic [IDX_W-1:0]   ic,
    input  logic [IDX_W-1:0]   ky,
    input  logic [IDX_W-1:0]   kx,
    input  logic [IDX_W-1:0]   in_ch,
    input  logic [IDX_W-1:0]   isize,
    input  logic [IDX_W-1:0]   ksz,
    input  logic [IDX_W-1:0]   stride,
    input  logic [IDX_W-1:0]   pad,
    output logic               tap_ok,
    output logic [FMAP_AW-1:0] fmap_addr,
    output logic [WGT_AW-1:0]  wgt_addr
);

    // Signed coordinates with headroom for stride scaling and negative padded positions
    localparam int unsigned CW = IDX_W + 3;
    localparam int unsigned PW = 2 * IDX_W;

    logic [PW-1:0]        oy_scaled, ox_scaled;
    logic signed [CW-1:0] row_s, col_s, size_s;
    logic                 row_ok, col_ok;

    always_comb begin
        oy_scaled = PW'(oy) * PW'(stride);
        ox_scaled = PW'(ox) * PW'(stride);
        size_s    = signed'(CW'(isize));
        row_s     = signed'(CW'(oy_scaled)) + signed'(CW'(ky)) - signed'(CW'(pad));
        col_s     = signed'(CW'(ox_scaled)) + signed'(CW'(kx)) - signed'(CW'(pad));
        row_ok    = (row_s >= 0) && (row_s < size_s);
        col_ok    = (col_s >= 0) && (col_s < size_s);
        tap_ok    = row_ok && col_ok;

        if (tap_ok) begin
            fmap_addr = (FMAP_AW'(ic) * FMAP_AW'(isize) + FMAP_AW'(row_s[IDX_W-1:0]))
                        * FMAP_AW'(isize) + FMAP_AW'(col_s[IDX_W-1:0]);
        end else begin
            fmap_addr = '0;
        end

        wgt_addr = ((WGT_AW'(oc) * WGT_AW'(in_ch) + WGT_AW'(ic)) * WGT_AW'(ksz)
                    + WGT_AW'(ky)) * WGT_AW'(ksz) + WGT_AW'(kx);
    end

endmodule

// File: rtl/conv_mac.sv
module conv_mac #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ACC_W  = 48,
    parameter int unsigned OUT_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic                     first,
    input  logic                     use_tap,
    input  logic signed [DATA_W-1:0] a_in,
    input  logic signed [DATA_W-1:0] b_in,
    output logic [OUT_W-1:0]         sat_out
);

    localparam int unsigned PW = 2 * DATA_W;
    localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [ACC_W-1:0] acc_q, acc_d;
    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext, base, sum;

    always_comb begin
        prod     = a_in * b_in;
        prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
        base     = first ? '0 : acc_q;
        sum      = base + (use_tap ? prod_ext : '0);
        acc_d    = step ? sum : acc_q;

        if (sum > SAT_HI) begin
            sat_out = SAT_HI[OUT_W-1:0];
        end else if (sum < SAT_LO) begin
            sat_out = SAT_LO[OUT_W-1:0];
        end else begin
            sat_out = sum[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/conv_engine.sv
module conv_engine
    import conv_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned ACC_W  = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [IDX_W-1:0]     cfg_in_ch,
    input  logic [IDX_W-1:0]     cfg_out_ch,
    input  logic [IDX_W-1:0]     cfg_in_size,
    input  logic [IDX_W-1:0]     cfg_kernel,
    input  logic [IDX_W-1:0]     cfg_stride,
    input  logic [IDX_W-1:0]     cfg_pad,
    output logic                 busy,
    output logic                 done,
    output logic [3*IDX_W-1:0]   fmap_addr,
    input  logic [DATA_W-1:0]    fmap_rdata,
    output logic [4*IDX_W-1:0]   wgt_addr,
    input  logic [DATA_W-1:0]    wgt_rdata,
    output logic                 out_we,
    output logic [3*IDX_W-1:0]   out_addr,
    output logic [2*DATA_W-1:0]  out_data
);

    localparam int unsigned OUT_W   = 2 * DATA_W;
    localparam int unsigned FMAP_AW = 3 * IDX_W;
    localparam int unsigned WGT_AW  = 4 * IDX_W;
    localparam int unsigned OUT_AW  = 3 * IDX_W;
    localparam int unsigned SPAN_W  = IDX_W + 2;

    typedef struct packed {
        eng_state_e        st;
        logic [IDX_W-1:0]  in_ch;
        logic [IDX_W-1:0]  out_ch;
        logic [IDX_W-1:0]  isize;
        logic [IDX_W-1:0]  ksz;
        logic [IDX_W-1:0]  stride;
        logic [IDX_W-1:0]  pad;
        logic [IDX_W-1:0]  osize;
        logic [OUT_AW-1:0] pix_idx;
        logic              we;
        logic [OUT_AW-1:0] waddr;
        logic [OUT_W-1:0]  wdata;
        logic              done;
    } eng_t;

    eng_t q, d;

    logic                             accept, running;
    logic [NUM_LOOPS-1:0][IDX_W-1:0]  limits, cnt;
    logic [NUM_LOOPS-1:0]             ends;
    logic                             first_tap, pix_last, run_last, tap_ok;
    logic [OUT_W-1:0]                 sat_word;
    logic [SPAN_W-1:0]                span, divisor;
    logic [IDX_W-1:0]                 osize_calc;

    assign accept  = start && (q.st == ST_IDLE);
    assign running = (q.st == ST_RUN);

    // Output side length from the live configuration inputs
    always_comb begin
        span       = SPAN_W'(cfg_in_size) + (SPAN_W'(cfg_pad) << 1) - SPAN_W'(cfg_kernel);
        divisor    = (cfg_stride == '0) ? SPAN_W'(1) : SPAN_W'(cfg_stride);
        osize_calc = IDX_W'(span / divisor) + 1'b1;
    end

    assign limits = {q.out_ch, q.osize, q.osize, q.in_ch, q.ksz, q.ksz};

    conv_loop_nest #(
        .IDX_W  (IDX_W),
        .LEVELS (NUM_LOOPS)
    ) nest_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .advance (running),
        .limit   (limits),
        .count   (cnt),
        .at_end  (ends)
    );

    conv_addr_gen #(
        .IDX_W   (IDX_W),
        .FMAP_AW (FMAP_AW),
        .WGT_AW  (WGT_AW)
    ) agen_i (
        .oc        (cnt[LP_OC]),
        .oy        (cnt[LP_OY]),
        .ox        (cnt[LP_OX]),
        .ic        (cnt[LP_IC]),
        .ky        (cnt[LP_KY]),
        .kx        (cnt[LP_KX]),
        .in_ch     (q.in_ch),
        .isize     (q.isize),
        .ksz       (q.ksz),
        .stride    (q.stride),
        .pad       (q.pad),
        .tap_ok    (tap_ok),
        .fmap_addr (fmap_addr),
        .wgt_addr  (wgt_addr)
    );

    assign first_tap = (cnt[LP_IC] == '0) && (cnt[LP_KY] == '0) && (cnt[LP_KX] == '0);
    assign pix_last  = ends[LP_IC] && ends[LP_KY] && ends[LP_KX];
    assign run_last  = &ends;

    conv_mac #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .OUT_W  (OUT_W)
    ) mac_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (running),
        .first   (first_tap),
        .use_tap (tap_ok),
        .a_in    (signed'(fmap_rdata)),
        .b_in    (signed'(wgt_rdata)),
        .sat_out (sat_word)
    );

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st      = ST_RUN;
                    d.in_ch   = cfg_in_ch;
                    d.out_ch  = cfg_out_ch;
                    d.isize   = cfg_in_size;
                    d.ksz     = cfg_kernel;
                    d.stride  = cfg_stride;
                    d.pad     = cfg_pad;
                    d.osize   = osize_calc;
                    d.pix_idx = '0;
                end
            end
            ST_RUN: begin
                if (pix_last) begin
                    d.we      = 1'b1;
                    d.waddr   = q.pix_idx;
                    d.wdata   = sat_word;
                    d.pix_idx = q.pix_idx + 1'b1;
                    if (run_last) begin
                        d.st = ST_FLUSH;
                    end
                end
            end
            ST_FLUSH: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign out_we   = q.we;
    assign out_addr = q.waddr;
    assign out_data = q.wdata;

endmodule

// File: rtl/conv_engine_chk.sv
module conv_engine_chk #(
    parameter int unsigned IDX_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               out_we,
    input logic [3*IDX_W-1:0] out_addr
);

    logic [3*IDX_W-1:0] exp_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_idx <= '0;
        end else if (start && !busy) begin
            exp_idx <= '0;
        end else if (out_we) begin
            exp_idx <= exp_idx + 1'b1;
        end
    end

    // R2: each write lands at the next running index
    assert_out_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> (out_addr == exp_idx));

    // R2: writes only happen inside a run
    assert_write_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> busy);

    // R1: busy only rises because a start was seen
    assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9: done is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done directly follows the final write
    assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_we));

    // R9: the engine is idle while done is high
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind conv_engine conv_engine_chk #(.IDX_W(IDX_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .out_we   (out_we),
    .out_addr (out_addr)
);

// File: tb/conv_engine_tb_top.sv
`timescale 1ns/1ps
module conv_engine_tb_top;

    localparam int DATA_W = 16;
    localparam int IDX_W  = 8;
    localparam int MEM_N  = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic               start = 1'b0;
    logic [IDX_W-1:0]   cfg_in_ch = '0, cfg_out_ch = '0, cfg_in_size = '0;
    logic [IDX_W-1:0]   cfg_kernel = '0, cfg_stride = '0, cfg_pad = '0;
    logic               busy, done, out_we;
    logic [3*IDX_W-1:0] fmap_addr, out_addr;
    logic [4*IDX_W-1:0] wgt_addr;
    logic [DATA_W-1:0]  fmap_rdata, wgt_rdata;
    logic [2*DATA_W-1:0] out_data;

    logic signed [15:0] fmap_mem [MEM_N];
    logic signed [15:0] wgt_mem  [MEM_N];
    logic [31:0]        out_mem  [MEM_N];
    longint             exp_mem  [MEM_N];

    int  vectors = 0;
    int  miscompares = 0;
    bit  finished = 1'b0;

    conv_engine #(.DATA_W(DATA_W), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_in_ch(cfg_in_ch), .cfg_out_ch(cfg_out_ch), .cfg_in_size(cfg_in_size),
        .cfg_kernel(cfg_kernel), .cfg_stride(cfg_stride), .cfg_pad(cfg_pad),
        .busy(busy), .done(done),
        .fmap_addr(fmap_addr), .fmap_rdata(fmap_rdata),
        .wgt_addr(wgt_addr), .wgt_rdata(wgt_rdata),
        .out_we(out_we), .out_addr(out_addr), .out_data(out_data)
    );

    assign fmap_rdata = fmap_mem[fmap_addr[10:0]];
    assign wgt_rdata  = wgt_mem[wgt_addr[10:0]];

    always @(posedge clk) begin
        if (out_we) out_mem[out_addr[10:0]] <= out_data;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint got, input longint expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    task automatic run_case(input int ic, input int oc, input int is, input int k,
                            input int s, input int p, input int fill,
                            input bit poke, input string req);
        int os, npix, ntaps, idx, cyc;
        // Memory contents
        for (int i = 0; i < MEM_N; i++) begin
            case (fill)
                1:       begin fmap_mem[i] = 16'sd32767; wgt_mem[i] = 16'sd32767; end
                2:       begin fmap_mem[i] = 16'sd32767; wgt_mem[i] = -16'sd32768; end
                default: begin
                    fmap_mem[i] = 16'(((i * 37 + 11) % 61) - 30);
                    wgt_mem[i]  = 16'(((i * 13 + 5) % 23) - 11);
                end
            endcase
            out_mem[i] = 32'hA5A5_A5A5;
        end
        // Reference loop nest (R3..R8)
        os    = (is + 2 * p - k) / s + 1;
        npix  = oc * os * os;
        ntaps = npix * ic * k * k;
        idx   = 0;
        for (int o = 0; o < oc; o++)
            for (int y = 0; y < os; y++)
                for (int x = 0; x < os; x++) begin
                    longint acc = 0;
                    for (int c = 0; c < ic; c++)
                        for (int i = 0; i < k; i++)
                            for (int j = 0; j < k; j++) begin
                                int r = y * s + i - p;
                                int q = x * s + j - p;
                                if (r >= 0 && r < is && q >= 0 && q < is)
                                    acc += longint'(fmap_mem[(c * is + r) * is + q])
                                         * longint'(wgt_mem[((o * ic + c) * k + i) * k + j]);
                            end
                    if (acc > 64'sd2147483647) acc = 64'sd2147483647;
                    if (acc < -64'sd2147483648) acc = -64'sd2147483648;
                    exp_mem[idx] = acc;
                    idx++;
                end
        // Launch
        @(negedge clk);
        cfg_in_ch = IDX_W'(ic); cfg_out_ch = IDX_W'(oc); cfg_in_size = IDX_W'(is);
        cfg_kernel = IDX_W'(k); cfg_stride = IDX_W'(s); cfg_pad = IDX_W'(p);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done) break;
            if (cyc > 20000) break;
            if (poke && cyc == 5) begin
                // R1: request during a run, with a different shape
                start = 1'b1; cfg_kernel = 8'd1; cfg_stride = 8'd1; cfg_pad = 8'd0;
                cfg_in_ch = 8'd1; cfg_out_ch = 8'd1;
            end
            if (poke && cyc == 6) begin
                start = 1'b0;
                cfg_in_ch = IDX_W'(ic); cfg_out_ch = IDX_W'(oc);
                cfg_kernel = IDX_W'(k); cfg_stride = IDX_W'(s); cfg_pad = IDX_W'(p);
            end
        end
        check(cyc == ntaps + 1, "R9", {req, " run length"}, longint'(cyc), longint'(ntaps + 1));
        @(posedge clk);
        @(negedge clk);
        check(!done, "R9", "done pulse width", longint'(done), 0);
        check(!busy, "R1", "idle after run", longint'(busy), 0);
        for (int i = 0; i < npix; i++) begin
            check(out_mem[i] == exp_mem[i][31:0], req, $sformatf("word %0d", i),
                  longint'($signed(out_mem[i])), exp_mem[i]);
        end
        // R8: nothing written past the last output word
        check(out_mem[npix] == 32'hA5A5_A5A5, "R8", "word past end",
              longint'(out_mem[npix]), longint'(32'hA5A5_A5A5));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: state held in reset
        check(!busy && !done && !out_we, "R10", "reset outputs",
              longint'({busy, done, out_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !out_we, "R10", "after release",
              longint'({busy, done, out_we}), 0);

        run_case(2, 2, 5, 3, 1, 0, 0, 1'b0, "R2 R4 R5 R6");
        run_case(2, 2, 6, 5, 2, 2, 0, 1'b1, "R1 R3 R8");
        run_case(1, 3, 4, 3, 1, 1, 0, 1'b0, "R3 R2");
        run_case(3, 1, 7, 2, 3, 0, 0, 1'b0, "R8 R4");
        run_case(1, 3, 2, 1, 2, 1, 0, 1'b1, "R1 R3");
        run_case(1, 1, 2, 2, 1, 0, 1, 1'b0, "R7");
        run_case(2, 1, 2, 2, 1, 0, 2, 1'b0, "R7");
        run_case(48, 1, 5, 5, 1, 0, 0, 1'b0, "R6 R5");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R9 watchdog: got no completion expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule